// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block turns single-word requests from a synchronous host into correctly timed pin sequences for an external asynchronous static RAM of 262144 words by 8 bits. The host raises a request with a direction flag, an 18-bit word address and, for writes, a data byte. The controller then shapes the memory's two chip selects, output enable and write enable, and drives or samples a split data bus (output value, output enable, input). When the access is over it returns a one-clock done pulse, and for a read the captured byte is valid on the read-data port in that same cycle.

Every strobe width is a whole number of clocks. These counts are worked out at elaboration time from a clock-period parameter and a speed-bin parameter (120 ns or 150 ns parts), always rounding up. Every write starts with a quiet turnaround phase in which output enable is already high. Only after that does the controller turn on its data driver, so it never fights a bus that the memory may still be releasing.

A retention input parks the memory deselected, for example while its supply is lowered to hold data. When retention is released, the controller stays idle for a programmable recovery time before it accepts new work.

Top module: `sram_link_ctrl`

## Requirements
- R1: While reset is high and right after it, the memory is deselected (mem_sel_n=1, mem_sel=0), mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, done=0, and ready=1 once reset is low.
- R2: A read holds mem_sel_n=0, mem_sel=1, mem_oe_n=0 and mem_we_n=1 for RD_CYC clocks, where RD_CYC is the larger of the cycle, address-access and output-enable times divided by the clock period and rounded up (6 at 20 ns and the 120 ns bin). mem_dq_in is captured at the last of these clocks. The next cycle shows rdata with done=1 for exactly one clock.
- R3: A write first spends TA_CYC clocks selected with mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0 (the larger of the two bus-release times, rounded up: 2). It then holds mem_we_n=0 and mem_dq_oe=1, with mem_dq_out equal to the request's wdata, for WP_CYC clocks: the largest of the write pulse, the data setup, and the address/select-to-end or cycle time less TA_CYC (4). mem_we_n, mem_dq_oe and both selects are released on the same edge, and done pulses for one clock.
- R4: mem_oe_n and mem_we_n are never low together, and mem_dq_oe is 1 only while the memory is selected with mem_we_n=0 and mem_oe_n=1.
- R5: During an access, mem_addr holds the accepted address. While mem_dq_oe=1, mem_dq_out stays constant.
- R6: ready=0 from acceptance until done. A req raised while ready=0 starts no access and changes no memory word.
- R7: With retain=1 in idle, the controller parks the memory deselected (mem_sel_n=1, mem_sel=0) with ready=0. Retain wins over a req in the same cycle, and a req while parked is ignored.
- R8: After retain falls, ready stays 0 and the memory stays deselected for WAKE_CYC clocks (the recovery time divided by the clock period, rounded up). ready then returns to 1.
- R9: A retain raised during an access lets that access complete with correct data and done. The controller then parks without starting anything else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, sampled when ready=1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write byte |
| retain | input | 1 | Park memory deselected for data retention |
| rdata | output | DATA_W | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| ready | output | 1 | Controller idle and accepting requests |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data value to drive onto the bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data read from the bus |

## Verification
A retention request and a host access can fall in the same cycle. The bench provokes this twice. First it raises retain together with a req while idle; there retain must win and no memory word may change. Second it raises retain the clock after a read has been accepted; that read must still finish with the right byte and the full strobe length, and the pins must then park deselected. The bench also fires a req while a write is in flight. It then judges, through a later read of the targeted address, that the stray request left memory untouched.

// File: rtl/sram_link_pkg.sv
package sram_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_PARK,
    ST_WAKE
  } link_state_t;

  // nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_link_timer.sv
module sram_link_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_link_fsm.sv
module sram_link_fsm
  import sram_link_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int RD_CYC   = 6,
  parameter int TA_CYC   = 2,
  parameter int WP_CYC   = 4,
  parameter int WAKE_CYC = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic             retain,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             launch,
  output logic             finish_wr,
  output logic             capture,
  output logic             sel_n,
  output logic             sel,
  output logic             oe_n,
  output logic             we_n,
  output logic             done,
  output logic             ready
);

  link_state_t st_q;

  always_comb begin
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    launch    = 1'b0;
    finish_wr = 1'b0;
    capture   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!retain && req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = wr ? CNT_W'(TA_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ:  capture = tmr_zero;
      ST_TURN: begin
        if (tmr_zero) begin
          launch   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WRITE: finish_wr = tmr_zero;
      ST_PARK: begin
        if (!retain) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WAKE_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      sel_n <= 1'b1;
      sel   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (retain) begin
            st_q <= ST_PARK;
          end else if (req) begin
            sel_n <= 1'b0;
            sel   <= 1'b1;
            if (wr) begin
              st_q <= ST_TURN;
            end else begin
              st_q <= ST_READ;
              oe_n <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            oe_n  <= 1'b1;
            sel_n <= 1'b1;
            sel   <= 1'b0;
            done  <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (tmr_zero) begin
            we_n <= 1'b0;
            st_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (tmr_zero) begin
            we_n  <= 1'b1;
            sel_n <= 1'b1;
            sel   <= 1'b0;
            done  <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_PARK: begin
          if (!retain) st_q <= ST_WAKE;
        end
        ST_WAKE: begin
          if (retain)        st_q <= ST_PARK;
          else if (tmr_zero) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready = (st_q == ST_IDLE);

  // R7
  park_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PARK) |-> (sel_n && !sel && oe_n && we_n));

  // R8
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAKE) |-> (sel_n && !sel && oe_n && we_n));

  // R6
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> !accept);

endmodule

// File: rtl/sram_link_dq.sv
module sram_link_dq #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              launch,
  input  logic              finish_wr,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr_in;
        dq_out   <= wdata_in;
      end
      if (launch)    dq_oe <= 1'b1;
      if (finish_wr) dq_oe <= 1'b0;
      if (capture)   rdata <= dq_in;
    end
  end

  // R5
  drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(dq_oe)) |-> ($stable(dq_out) && $stable(mem_addr)));

endmodule

// File: rtl/sram_link_ctrl.sv
module sram_link_ctrl
  import sram_link_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int SPEED_BIN = 0,
  parameter int WAKE_NS   = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              retain,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  // per-bin memory limits in ns
  localparam int T_CYC = (SPEED_BIN == 0) ? 120 : 150;
  localparam int T_OE  = (SPEED_BIN == 0) ? 60  : 75;
  localparam int T_OHZ = (SPEED_BIN == 0) ? 35  : 40;
  localparam int T_WHZ = (SPEED_BIN == 0) ? 30  : 40;
  localparam int T_WP  = (SPEED_BIN == 0) ? 80  : 100;
  localparam int T_DW  = (SPEED_BIN == 0) ? 50  : 60;
  localparam int T_AW  = (SPEED_BIN == 0) ? 100 : 120;

  localparam int RD_CYC   = ns2cyc(imax(T_CYC, T_OE), CLK_NS);
  localparam int TA_CYC   = ns2cyc(imax(T_OHZ, T_WHZ), CLK_NS);
  localparam int WP_CYC   = imax(imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DW, CLK_NS)),
                                 imax(ns2cyc(imax(T_AW, T_CYC), CLK_NS) - TA_CYC, 1));
  localparam int WAKE_CYC = ns2cyc(WAKE_NS, CLK_NS);
  localparam int CNT_W    = $clog2(imax(imax(RD_CYC, WP_CYC), imax(TA_CYC, WAKE_CYC)) + 1);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, launch, finish_wr, capture;

  sram_link_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_link_fsm #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .TA_CYC   (TA_CYC),
    .WP_CYC   (WP_CYC),
    .WAKE_CYC (WAKE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .wr        (wr),
    .retain    (retain),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .launch    (launch),
    .finish_wr (finish_wr),
    .capture   (capture),
    .sel_n     (mem_sel_n),
    .sel       (mem_sel),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .done      (done),
    .ready     (ready)
  );

  sram_link_dq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .launch    (launch),
    .finish_wr (finish_wr),
    .capture   (capture),
    .addr_in   (addr),
    .wdata_in  (wdata),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .rdata     (rdata)
  );

  // length of the current write-enable low run, for the pulse check
  logic [CNT_W-1:0] we_low_q;
  always_ff @(posedge clk) begin
    if (rst)            we_low_q <= '0;
    else if (!mem_we_n) we_low_q <= we_low_q + 1'b1;
    else                we_low_q <= '0;
  end

  // R4
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R4
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_sel_n && mem_sel));

  // R3
  turn_before_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_we_n) && !$past(mem_sel_n)));

  // R3
  wp_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_q == CNT_W'(WP_CYC)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/sim_sram_link_ctrl.sv
module sim_sram_link_ctrl;

  localparam int AW = 18;
  localparam int DW = 8;
  localparam int EXP_RD   = 6;   // R2: ceil(120/20)
  localparam int EXP_TA   = 2;   // R3: ceil(35/20)
  localparam int EXP_WP   = 4;   // R3: max(4,3,6-2)
  localparam int WAKE_NS  = 1000;
  localparam int EXP_WAKE = 50;  // R8: 1000/20

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr = 1'b0, retain = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, mem_dq_out;
  logic [DW-1:0] mdq_in = 8'hEE;
  logic done, ready, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  sram_link_ctrl #(.WAKE_NS(WAKE_NS)) u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .retain(retain), .rdata(rdata), .done(done), .ready(ready),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mdq_in)
  );

  int tests = 0, failed = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {6'b0, a[17:16]};
  endfunction

  typedef struct { bit w; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t q[$];
  logic [7:0] mem     [logic [AW-1:0]];  // pin-level memory model
  logic [7:0] exp_mem [logic [AW-1:0]];  // expectation shadow

  // pin monitor and memory model
  int oe_run = 0, last_oe = 0, ta_run = 0, last_ta = 0, we_run = 0, last_we = 0;
  int conflict = 0, unstable = 0, park_err = 0;
  bit retain_watch = 0;
  logic [7:0] first_d, hold_d;
  logic [AW-1:0] hold_a;

  always @(negedge clk) begin
    automatic bit sel_on = !mem_sel_n && mem_sel;
    automatic item_t it;
    if (!rst) begin
      if ((!mem_oe_n && !mem_we_n) ||
          (mem_dq_oe && !(sel_on && !mem_we_n && mem_oe_n))) conflict++;
      if (retain_watch && sel_on) park_err++;
      if (sel_on && !mem_oe_n) oe_run++;
      else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
      if (sel_on && mem_we_n && mem_oe_n) ta_run++;
      else begin
        if (!mem_we_n && ta_run != 0) last_ta = ta_run;
        ta_run = 0;
      end
      if (!mem_we_n) begin
        if (we_run == 0) first_d = mem_dq_out;
        else if (mem_dq_out != first_d) unstable++;
        we_run++;
        hold_d = mem_dq_out;
        hold_a = mem_addr;
      end else if (we_run != 0) begin
        last_we = we_run;
        mem[hold_a] = hold_d;
        we_run = 0;
      end
      mdq_in = (sel_on && !mem_oe_n && mem_we_n) ?
               (mem.exists(mem_addr) ? mem[mem_addr] : dflt(mem_addr)) : 8'hEE;
      if (done) begin
        if (q.size() == 0) chk(0, "R2", "unexpected done", 1, 0);
        else begin
          it = q.pop_front();
          if (it.w) begin
            chk((mem.exists(it.a) ? mem[it.a] : dflt(it.a)) == it.d, "R3", "written word",
                mem.exists(it.a) ? mem[it.a] : dflt(it.a), it.d);
            chk(last_we == EXP_WP, "R3", "we_n low clocks", last_we, EXP_WP);
            chk(last_ta == EXP_TA, "R3", "turnaround clocks", last_ta, EXP_TA);
          end else begin
            chk(rdata == it.d, "R2", "read data", rdata, it.d);
            chk(last_oe == EXP_RD, "R2", "oe_n low clocks", last_oe, EXP_RD);
          end
        end
      end
    end
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    while (!ready) @(negedge clk);
    it.w = w; it.a = a;
    if (w) begin it.d = d; exp_mem[a] = d; end
    else it.d = exp_mem.exists(a) ? exp_mem[a] : dflt(a);
    q.push_back(it);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    int n, sel_seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_sel_n == 1'b1, "R1", "mem_sel_n", mem_sel_n, 1);
    chk(mem_sel == 1'b0,   "R1", "mem_sel",   mem_sel,   0);
    chk(mem_oe_n && mem_we_n, "R1", "oe_n&we_n", {mem_oe_n, mem_we_n}, 3);
    chk(!mem_dq_oe && !done, "R1", "dq_oe|done", {mem_dq_oe, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);

    // R2 reads of unwritten boundary words
    issue(0, 18'h00000, 0); wait_idle();
    issue(0, 18'h3FFFF, 0); wait_idle();
    // R3 writes with edge data, then read back
    issue(1, 18'h00000, 8'h00); issue(1, 18'h3FFFF, 8'hFF);
    issue(1, 18'h12345, 8'hA5); issue(0, 18'h3FFFF, 0);
    issue(0, 18'h00000, 0); issue(0, 18'h12345, 0);
    wait_idle();
    // R4 alternating write/read back to back
    for (int i = 0; i < 8; i++) begin
      issue(1, 18'(i * 4099), 8'(8'h11 * i + 3));
      issue(0, 18'(i * 4099), 0);
    end
    wait_idle();

    // R6 request while busy is ignored
    issue(1, 18'h00100, 8'h3C);
    chk(ready == 1'b0, "R6", "ready while busy", ready, 0);
    pulse_req(1, 18'h00200, 8'h77);
    wait_idle();
    sel_seen = 0;
    repeat (5) begin
      if (!mem_sel_n) sel_seen++;
      @(negedge clk);
    end
    chk(sel_seen == 0, "R6", "stray access clocks", sel_seen, 0);
    issue(0, 18'h00200, 0); wait_idle();

    // R7 retain wins over same-cycle req; req while parked ignored
    retain = 1'b1;
    pulse_req(1, 18'h00300, 8'h99);
    retain_watch = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0, "R7", "ready while parked", ready, 0);
    chk(mem_sel_n && !mem_sel, "R7", "parked selects", {mem_sel_n, mem_sel}, 2);
    pulse_req(1, 18'h00301, 8'h98);
    repeat (4) @(negedge clk);
    // R8 recovery time
    retain = 1'b0;
    n = 0;
    @(negedge clk);
    while (!ready) begin n++; @(negedge clk); end
    chk(n == EXP_WAKE, "R8", "wake clocks", n, EXP_WAKE);
    retain_watch = 1'b0;
    chk(park_err == 0, "R8", "selected while parked/waking", park_err, 0);
    issue(0, 18'h00300, 0); issue(0, 18'h00301, 0); wait_idle();

    // R9 retain during an access
    issue(1, 18'h00777, 8'hC3);
    wait_idle();
    issue(0, 18'h00777, 0);
    retain = 1'b1;
    wait_idle();
    chk(ready == 1'b0, "R9", "parked after access", ready, 0);
    chk(mem_sel_n == 1'b1, "R9", "deselected after access", mem_sel_n, 1);
    retain = 1'b0;
    while (!ready) @(negedge clk);
    issue(0, 18'h00777, 0); wait_idle();

    // R4 and R5 pin-level rules over the whole run
    chk(conflict == 0, "R4", "strobe/driver conflicts", conflict, 0);
    chk(unstable == 0, "R5", "drive data changes", unstable, 0);
    chk(q.size() == 0, "R2", "outstanding items", q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule